// File: doc/BRIEF.md
# Serial NAND Bad-Block Scanner

This block brings up a serial NAND device once after reset. When `start` is pulsed it resets the device and reads its identifier. If the identifier is on the supported list, it visits every erase block and records whether that block is bad. Last, it programs the device's block-protection feature to leave the array either open or write-protected, as the read-only strap selects.

Bus traffic goes out through a transaction-level port to an SPI master. For each transaction the block presents an opcode, up to three address bytes, an optional write byte and a read length. It pulses `spi_start` and holds every field until the master returns `spi_done` with the received bytes. Two things are kept as results: a one-bit-per-block bad map and a population count of that map. Other logic reads the map through a read port and can mark further blocks bad at run time through a set port. The scan ends with `done` high and an error code on `err`.

Top module: `nand_badblock_scan`

## Requirements
- R1: Out of reset, `done` is 0, `err` is 0, `spi_start` is 0, `bad_count` is 0 and every bit of the bad map reads 0.
- R2: On `start`, the block issues opcode 0xFF (no address, no data), waits at least `RST_GAP` cycles after its completion, and issues 0xFF again. It then waits at least `RST_SETTLE` cycles and issues opcode 0x9F with no address and 2 read bytes.
- R3: If the identifier (the 2 read bytes, first byte most significant) matches no entry of `ID_LIST`, the block sets `done` with `err` = 1. It issues no further transaction and leaves the map empty. A nonzero `err` is only ever seen with `done` high.
- R4: Blocks are scanned in ascending order. Each block first gets opcode 0x13 with 3 address bytes, equal to the block number shifted left by `PAGE_SHIFT`. Then the block polls opcode 0x0F with 1 address byte 0xC0 and 1 read byte, at least `POLL_GAP` cycles apart, until bit 0 of the returned byte is 0. The other status bits are ignored.
- R5: Next comes opcode 0x03 with 3 address bytes {column 0x0800, 0x00} and 1 read byte. Any value other than 0xFF marks the block bad, and no second read is made for that block.
- R6: Otherwise the block issues opcode 0x03 with address {0x0808, 0x00} and 4 read bytes. Exactly 0xDEADBEEF marks the block bad, and any other value leaves it good.
- R7: If `POLL_LIMIT` polls of one block all return bit 0 set, the block sets `done` with `err` = 2 and issues nothing more.
- R8: After the last block, the block issues opcode 0x1F with address byte 0xA0 and one write byte: 0x38 if `ro_strap` was high at `start`, else 0x00. After that it sets `done` with `err` = 0. No transaction is issued once `done` is high.
- R9: `rd_bad` shows the map bit of `rd_blk` one cycle after `rd_blk` is applied. `bad_count` equals the number of set bits.
- R10: A `mark_valid` pulse sets the bit of `mark_blk`. `bad_count` rises by one only if that bit was clear, and it never decreases.
- R11: `start` is ignored while a run is in progress and after `done`. `done` stays high until reset.
- R12: At most one transaction is outstanding at a time. All request fields stay stable from `spi_start` until `spi_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the one-shot bring-up |
| ro_strap | input | 1 | Leave array write-protected when high |
| done | output | 1 | Bring-up finished (sticky) |
| err | output | 2 | 0 none, 1 unknown device, 2 busy timeout |
| spi_start | output | 1 | One-cycle transaction request |
| spi_op | output | 8 | Opcode byte |
| spi_addr | output | 24 | Address; the low `spi_alen` bytes are sent, most significant first |
| spi_alen | output | 2 | Number of address bytes |
| spi_wlen | output | 1 | One write byte follows the address |
| spi_wdata | output | 8 | Write byte |
| spi_rlen | output | 3 | Bytes to read (0 to 4) |
| spi_done | input | 1 | Transaction complete |
| spi_rdata | input | 32 | Read bytes, right-aligned, first received most significant |
| rd_blk | input | BLK_W | Map read address |
| rd_bad | output | 1 | Map bit of `rd_blk` |
| mark_valid | input | 1 | Run-time mark request |
| mark_blk | input | BLK_W | Block to mark bad |
| bad_count | output | CNT_W | Number of bad blocks |

## Verification
On every cycle the assertions check the transaction discipline: a single outstanding request, fields held stable, only legal opcodes, and silence once finished. They also check that `done` is sticky, that an error code only appears with `done`, and that the bad count is monotonic and bounded. The order of the transactions, the marker decisions per block, the reset and poll spacing, the identifier rejection, the timeout abort and the lock byte chosen by the strap are all shown only by the bench scenarios. There, the bench replays an independently built transaction list against a device model whose markers and busy behaviour vary from block to block.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
   typedef enum logic [1:0] {
      ERR_NONE  = 2'd0,
      ERR_NODEV = 2'd1,
      ERR_IO    = 2'd2
   } nbs_err_e;

   localparam logic [7:0] OP_RESET     = 8'hFF;
   localparam logic [7:0] OP_READ_ID   = 8'h9F;
   localparam logic [7:0] OP_PAGE_LOAD = 8'h13;
   localparam logic [7:0] OP_GET_FEAT  = 8'h0F;
   localparam logic [7:0] OP_CACHE_RD  = 8'h03;
   localparam logic [7:0] OP_SET_FEAT  = 8'h1F;

   localparam logic [7:0] FEAT_STATUS  = 8'hC0;
   localparam logic [7:0] FEAT_PROTECT = 8'hA0;
   localparam logic [7:0] PROT_OPEN    = 8'h00;
   localparam logic [7:0] PROT_RDONLY  = 8'h38;

   typedef enum logic [3:0] {
      S_IDLE, S_RST1, S_GAP1, S_RST2, S_SETTLE, S_IDRD,
      S_LOAD, S_POLL, S_PGAP, S_FACT, S_USER, S_LOCK, S_FIN
   } nbs_state_e;

   typedef struct packed {
      logic [7:0]  op;
      logic [23:0] addr;
      logic [1:0]  alen;
      logic        wlen;
      logic [7:0]  wdata;
      logic [2:0]  rlen;
   } nbs_txn_t;
endpackage

// File: rtl/nbs_timer.sv
module nbs_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic             expired
);
   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/nbs_bitmap.sv
module nbs_bitmap #(
   parameter int NUM_BLOCKS = 1024,
   parameter int BLK_W      = 10,
   parameter int CNT_W      = 11,
   parameter bit REG_READ   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_a,
   input  logic [BLK_W-1:0] blk_a,
   input  logic             set_b,
   input  logic [BLK_W-1:0] blk_b,
   input  logic [BLK_W-1:0] rd_blk,
   output logic             rd_bad,
   output logic [CNT_W-1:0] count
);
   logic [NUM_BLOCKS-1:0] bits;
   logic                  new_a, new_b;
   logic [CNT_W-1:0]      cnt_q;

   for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if ((set_a && blk_a == BLK_W'(g)) || (set_b && blk_b == BLK_W'(g)))
            bit_q <= 1'b1;
      end
      assign bits[g] = bit_q;
   end

   // a block set by both ports in one cycle is counted once
   assign new_a = set_a && !bits[blk_a];
   assign new_b = set_b && !bits[blk_b] && !(set_a && blk_a == blk_b);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + CNT_W'(new_a) + CNT_W'(new_b);
   end
   assign count = cnt_q;

   if (REG_READ) begin : g_rd_reg
      logic rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= 1'b0;
         else        rd_q <= bits[rd_blk];
      end
      assign rd_bad = rd_q;
   end else begin : g_rd_comb
      assign rd_bad = bits[rd_blk];
   end
endmodule

// File: rtl/nbs_seq.sv
module nbs_seq
   import nbs_pkg::*;
#(
   parameter int                 NUM_BLOCKS = 1024,
   parameter int                 BLK_W      = 10,
   parameter int                 PAGE_SHIFT = 6,
   parameter logic [15:0]        SPARE_COL  = 16'h0800,
   parameter int                 USER_OFS   = 8,
   parameter logic [31:0]        USER_MARK  = 32'hDEADBEEF,
   parameter int                 NUM_IDS    = 2,
   parameter logic [NUM_IDS*16-1:0] ID_LIST = {16'h2C13, 16'h2C12},
   parameter int                 RST_GAP    = 12500,
   parameter int                 RST_SETTLE = 50000,
   parameter int                 POLL_GAP   = 2500,
   parameter int                 POLL_LIMIT = 200,
   parameter int                 TMR_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ro_strap,
   output nbs_txn_t         txn,
   output logic             spi_start,
   input  logic             spi_done,
   input  logic [31:0]      spi_rdata,
   output logic             tmr_load,
   output logic [TMR_W-1:0] tmr_val,
   input  logic             tmr_zero,
   output logic             scan_set,
   output logic [BLK_W-1:0] scan_blk,
   output logic             done,
   output nbs_err_e         err
);
   localparam int          PW       = $clog2(POLL_LIMIT) + 1;
   localparam logic [15:0] USER_COL = SPARE_COL + 16'(USER_OFS);

   nbs_state_e       state_q, state_n;
   logic [BLK_W-1:0] blk_q, blk_n;
   logic [PW-1:0]    poll_q, poll_n;
   nbs_err_e         err_q, err_n;
   logic             ro_q, inflight_q, is_txn, fin, last_blk, any_id;
   logic [NUM_IDS-1:0] id_hit;
   logic [23:0]      row;

   for (genvar g = 0; g < NUM_IDS; g++) begin : g_id
      assign id_hit[g] = (spi_rdata[15:0] == ID_LIST[g*16 +: 16]);
   end
   assign any_id = |id_hit;

   assign is_txn = state_q inside {S_RST1, S_RST2, S_IDRD, S_LOAD,
                                   S_POLL, S_FACT, S_USER, S_LOCK};
   assign spi_start = is_txn && !inflight_q;
   assign fin       = inflight_q && spi_done;
   assign last_blk  = (blk_q == BLK_W'(NUM_BLOCKS - 1));
   assign row       = 24'(blk_q) << PAGE_SHIFT;

   always_comb begin
      txn = '0;
      case (state_q)
         S_RST1, S_RST2: txn.op = OP_RESET;
         S_IDRD: begin
            txn.op   = OP_READ_ID;
            txn.rlen = 3'd2;
         end
         S_LOAD: begin
            txn.op   = OP_PAGE_LOAD;
            txn.addr = row;
            txn.alen = 2'd3;
         end
         S_POLL: begin
            txn.op   = OP_GET_FEAT;
            txn.addr = {16'h0000, FEAT_STATUS};
            txn.alen = 2'd1;
            txn.rlen = 3'd1;
         end
         S_FACT: begin
            txn.op   = OP_CACHE_RD;
            txn.addr = {SPARE_COL, 8'h00};
            txn.alen = 2'd3;
            txn.rlen = 3'd1;
         end
         S_USER: begin
            txn.op   = OP_CACHE_RD;
            txn.addr = {USER_COL, 8'h00};
            txn.alen = 2'd3;
            txn.rlen = 3'd4;
         end
         S_LOCK: begin
            txn.op    = OP_SET_FEAT;
            txn.addr  = {16'h0000, FEAT_PROTECT};
            txn.alen  = 2'd1;
            txn.wlen  = 1'b1;
            txn.wdata = ro_q ? PROT_RDONLY : PROT_OPEN;
         end
         default: txn = '0;
      endcase
   end

   always_comb begin
      state_n  = state_q;
      blk_n    = blk_q;
      poll_n   = poll_q;
      err_n    = err_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      scan_set = 1'b0;
      case (state_q)
         S_IDLE:   if (start) state_n = S_RST1;
         S_RST1:   if (fin) begin
                      state_n  = S_GAP1;
                      tmr_load = 1'b1;
                      tmr_val  = TMR_W'(RST_GAP);
                   end
         S_GAP1:   if (tmr_zero) state_n = S_RST2;
         S_RST2:   if (fin) begin
                      state_n  = S_SETTLE;
                      tmr_load = 1'b1;
                      tmr_val  = TMR_W'(RST_SETTLE);
                   end
         S_SETTLE: if (tmr_zero) state_n = S_IDRD;
         S_IDRD:   if (fin) begin
                      if (any_id) begin
                         state_n = S_LOAD;
                         blk_n   = '0;
                      end else begin
                         state_n = S_FIN;
                         err_n   = ERR_NODEV;
                      end
                   end
         S_LOAD:   if (fin) begin
                      state_n = S_POLL;
                      poll_n  = '0;
                   end
         S_POLL:   if (fin) begin
                      if (!spi_rdata[0]) begin
                         state_n = S_FACT;
                      end else if (poll_q == PW'(POLL_LIMIT - 1)) begin
                         state_n = S_FIN;
                         err_n   = ERR_IO;
                      end else begin
                         poll_n   = poll_q + 1'b1;
                         state_n  = S_PGAP;
                         tmr_load = 1'b1;
                         tmr_val  = TMR_W'(POLL_GAP);
                      end
                   end
         S_PGAP:   if (tmr_zero) state_n = S_POLL;
         S_FACT, S_USER:
                   if (fin) begin
                      if (state_q == S_FACT && spi_rdata[7:0] == 8'hFF) begin
                         state_n = S_USER;
                      end else begin
                         scan_set = (state_q == S_FACT) || (spi_rdata == USER_MARK);
                         if (last_blk) begin
                            state_n = S_LOCK;
                         end else begin
                            blk_n   = blk_q + 1'b1;
                            state_n = S_LOAD;
                         end
                      end
                   end
         S_LOCK:   if (fin) state_n = S_FIN;
         default:  state_n = state_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         blk_q      <= '0;
         poll_q     <= '0;
         err_q      <= ERR_NONE;
         ro_q       <= 1'b0;
         inflight_q <= 1'b0;
      end else begin
         state_q <= state_n;
         blk_q   <= blk_n;
         poll_q  <= poll_n;
         err_q   <= err_n;
         if (state_q == S_IDLE && start) ro_q <= ro_strap;
         if (spi_start)  inflight_q <= 1'b1;
         else if (fin)   inflight_q <= 1'b0;
      end
   end

   assign scan_blk = blk_q;
   assign done     = (state_q == S_FIN);
   assign err      = err_q;
endmodule

// File: rtl/nand_badblock_scan.sv
module nand_badblock_scan
   import nbs_pkg::*;
#(
   parameter int                    NUM_BLOCKS = 1024,
   parameter int                    PAGE_SHIFT = 6,
   parameter logic [15:0]           SPARE_COL  = 16'h0800,
   parameter int                    USER_OFS   = 8,
   parameter logic [31:0]           USER_MARK  = 32'hDEADBEEF,
   parameter int                    NUM_IDS    = 2,
   parameter logic [NUM_IDS*16-1:0] ID_LIST    = {16'h2C13, 16'h2C12},
   parameter int                    RST_GAP    = 12500,
   parameter int                    RST_SETTLE = 50000,
   parameter int                    POLL_GAP   = 2500,
   parameter int                    POLL_LIMIT = 200,
   parameter bit                    REG_READ   = 1'b1,
   localparam int                   BLK_W      = $clog2(NUM_BLOCKS),
   localparam int                   CNT_W      = $clog2(NUM_BLOCKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ro_strap,
   output logic             done,
   output logic [1:0]       err,
   output logic             spi_start,
   output logic [7:0]       spi_op,
   output logic [23:0]      spi_addr,
   output logic [1:0]       spi_alen,
   output logic             spi_wlen,
   output logic [7:0]       spi_wdata,
   output logic [2:0]       spi_rlen,
   input  logic             spi_done,
   input  logic [31:0]      spi_rdata,
   input  logic [BLK_W-1:0] rd_blk,
   output logic             rd_bad,
   input  logic             mark_valid,
   input  logic [BLK_W-1:0] mark_blk,
   output logic [CNT_W-1:0] bad_count
);
   localparam int TMR_MAX_A = (RST_GAP > RST_SETTLE) ? RST_GAP : RST_SETTLE;
   localparam int TMR_MAX   = (TMR_MAX_A > POLL_GAP) ? TMR_MAX_A : POLL_GAP;
   localparam int TMR_W     = $clog2(TMR_MAX + 1);

   if (NUM_BLOCKS < 2 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_chk_blocks
      $error("NUM_BLOCKS must be a power of two of at least 2");
   end
   if (POLL_LIMIT < 1) begin : g_chk_poll
      $error("POLL_LIMIT must be at least 1");
   end
   if (PAGE_SHIFT + BLK_W > 24) begin : g_chk_row
      $error("row address does not fit in three bytes");
   end
   if (NUM_IDS < 1) begin : g_chk_ids
      $error("ID_LIST needs at least one entry");
   end

   nbs_txn_t         txn;
   logic             tmr_load, tmr_zero, scan_set;
   logic [TMR_W-1:0] tmr_val;
   logic [BLK_W-1:0] scan_blk;
   nbs_err_e         err_e;

   nbs_seq #(
      .NUM_BLOCKS (NUM_BLOCKS), .BLK_W(BLK_W), .PAGE_SHIFT(PAGE_SHIFT),
      .SPARE_COL  (SPARE_COL),  .USER_OFS(USER_OFS), .USER_MARK(USER_MARK),
      .NUM_IDS    (NUM_IDS),    .ID_LIST(ID_LIST),
      .RST_GAP    (RST_GAP),    .RST_SETTLE(RST_SETTLE),
      .POLL_GAP   (POLL_GAP),   .POLL_LIMIT(POLL_LIMIT), .TMR_W(TMR_W)
   ) u_seq (
      .clk, .rst_n, .start, .ro_strap,
      .txn, .spi_start, .spi_done, .spi_rdata,
      .tmr_load, .tmr_val, .tmr_zero,
      .scan_set, .scan_blk, .done, .err(err_e)
   );

   nbs_timer #(.TMR_W(TMR_W)) u_timer (
      .clk, .rst_n, .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
   );

   nbs_bitmap #(
      .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .CNT_W(CNT_W), .REG_READ(REG_READ)
   ) u_map (
      .clk, .rst_n,
      .set_a(scan_set),   .blk_a(scan_blk),
      .set_b(mark_valid), .blk_b(mark_blk),
      .rd_blk, .rd_bad, .count(bad_count)
   );

   assign err       = err_e;
   assign spi_op    = txn.op;
   assign spi_addr  = txn.addr;
   assign spi_alen  = txn.alen;
   assign spi_wlen  = txn.wlen;
   assign spi_wdata = txn.wdata;
   assign spi_rlen  = txn.rlen;
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
   parameter int NUM_BLOCKS = 1024,
   localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic [1:0]       err,
   input logic             spi_start,
   input logic [7:0]       spi_op,
   input logic [23:0]      spi_addr,
   input logic [1:0]       spi_alen,
   input logic             spi_wlen,
   input logic [7:0]       spi_wdata,
   input logic [2:0]       spi_rlen,
   input logic             spi_done,
   input logic [CNT_W-1:0] bad_count
);
   logic outst;

   always_ff @(posedge clk) begin
      if (!rst_n)         outst <= 1'b0;
      else if (spi_start) outst <= 1'b1;
      else if (spi_done)  outst <= 1'b0;
   end

   assert_single_txn_R12: assert property (@(posedge clk) disable iff (!rst_n)
      outst |-> !spi_start);

   assert_fields_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_start || (outst && !spi_done)) |=>
         ($stable(spi_op) && $stable(spi_addr) && $stable(spi_alen) &&
          $stable(spi_wlen) && $stable(spi_wdata) && $stable(spi_rlen)));

   assert_legal_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |-> (spi_op inside {8'hFF, 8'h9F, 8'h13, 8'h0F, 8'h03, 8'h1F}));

   assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   assert_err_needs_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (err != 2'd0) |-> done);

   assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !spi_start);

   assert_count_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_done || !spi_done) |=> (bad_count >= $past(bad_count)));

   assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bad_count <= CNT_W'(NUM_BLOCKS));
endmodule

bind nand_badblock_scan nbs_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_nbs_checker (
   .clk(clk), .rst_n(rst_n), .done(done), .err(err),
   .spi_start(spi_start), .spi_op(spi_op), .spi_addr(spi_addr),
   .spi_alen(spi_alen), .spi_wlen(spi_wlen), .spi_wdata(spi_wdata),
   .spi_rlen(spi_rlen), .spi_done(spi_done), .bad_count(bad_count)
);

// File: tb/tb_nand_badblock_scan.sv
module tb_nand_badblock_scan;
   localparam int NB = 1024, BW = 10, CW = 11;
   localparam int GAP = 20, SETTLE = 40, PGAP = 3, PLIM = 4, LAT = 2;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ro_strap = 1'b0;
   logic done, rd_bad, spi_start, spi_wlen;
   logic [1:0] err, spi_alen;
   logic [7:0] spi_op, spi_wdata;
   logic [23:0] spi_addr;
   logic [2:0] spi_rlen;
   logic spi_done = 1'b0;
   logic [31:0] spi_rdata = '0;
   logic [BW-1:0] rd_blk = '0, mark_blk = '0;
   logic mark_valid = 1'b0;
   logic [CW-1:0] bad_count;

   nand_badblock_scan #(.RST_GAP(GAP), .RST_SETTLE(SETTLE), .POLL_GAP(PGAP),
                        .POLL_LIMIT(PLIM)) dut (.*);

   always #10 clk = ~clk;

   int checks = 0, errors = 0, txn_seen = 0;
   longint cyc = 0, last_done_cyc = 0;
   logic [45:0] exp_q[$];
   logic [31:0] rsp_q[$];
   bit exp_bits[NB];
   int exp_cnt;
   bit prev_busy = 0, prev_done = 0;

   always @(posedge clk) cyc++;

   task automatic chk(bit ok, string req, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [7:0] fact_byte(int b);
      return (b % 97 == 5) ? 8'h00 : ((b % 131 == 9) ? 8'hF0 : 8'hFF);
   endfunction
   function automatic logic [31:0] user_word(int b);
      return (b % 61 == 7) ? 32'hDEADBEEF : ((b % 50 == 3) ? 32'hDEADBEEE : 32'hFFFFFFFF);
   endfunction
   function automatic string tag_of(logic [45:0] e);
      case (e[45:38])
         8'hFF, 8'h9F: return "R2";
         8'h13, 8'h0F: return "R4";
         8'h1F:        return "R8";
         default:      return (e[37:22] == 16'h0808) ? "R6" : "R5";
      endcase
   endfunction

   task automatic push(logic [7:0] op, logic [23:0] a, logic [1:0] al, logic wl,
                       logic [7:0] wd, logic [2:0] rl, logic [31:0] rsp);
      exp_q.push_back({op, a, al, wl, wd, rl});
      rsp_q.push_back(rsp);
   endtask

   task automatic build(logic [15:0] id, bit ro, int stuck);
      exp_q.delete(); rsp_q.delete(); exp_cnt = 0; txn_seen = 0;
      foreach (exp_bits[i]) exp_bits[i] = 0;
      push(8'hFF, 0, 0, 0, 0, 0, 0);
      push(8'hFF, 0, 0, 0, 0, 0, 0);
      push(8'h9F, 0, 0, 0, 0, 2, {16'h0, id});
      if (id != 16'h2C12 && id != 16'h2C13) return;
      for (int b = 0; b < NB; b++) begin
         push(8'h13, 24'(b) << 6, 3, 0, 0, 0, 0);
         if (b == stuck) begin
            for (int k = 0; k < PLIM; k++) push(8'h0F, 24'hC0, 1, 0, 0, 1, 32'h11);
            return;
         end
         for (int k = 0; k < b % 3; k++)
            push(8'h0F, 24'hC0, 1, 0, 0, 1, (b % 2) ? 32'h11 : 32'h01);
         push(8'h0F, 24'hC0, 1, 0, 0, 1, (b % 4 == 1) ? 32'h20 : 32'h00);
         push(8'h03, 24'h080000, 3, 0, 0, 1, {24'h0, fact_byte(b)});
         if (fact_byte(b) != 8'hFF) begin
            exp_bits[b] = 1; exp_cnt++;
         end else begin
            push(8'h03, 24'h080800, 3, 0, 0, 4, user_word(b));
            if (user_word(b) == 32'hDEADBEEF) begin exp_bits[b] = 1; exp_cnt++; end
         end
      end
      push(8'h1F, 24'hA0, 1, 1, ro ? 8'h38 : 8'h00, 0, 0);
   endtask

   // device responder and request checker
   initial begin
      int wait_cnt = 0;
      logic [31:0] pend = '0;
      forever begin
         @(negedge clk);
         spi_done = 1'b0;
         if (!rst_n) begin
            wait_cnt = 0; prev_busy = 0;
         end else begin
            if (wait_cnt > 0) begin
               wait_cnt--;
               if (wait_cnt == 0) begin
                  spi_done = 1'b1; spi_rdata = pend; last_done_cyc = cyc;
               end
            end
            if (spi_start) begin
               logic [45:0] got, e;
               got = {spi_op, spi_addr, spi_alen, spi_wlen, spi_wdata, spi_rlen};
               chk(wait_cnt == 0, "R12", "request while busy", 1, 0);
               if (exp_q.size() == 0) begin
                  chk(0, "R8", "unexpected transaction", got, 0);
                  pend = '0;
               end else begin
                  e = exp_q.pop_front();
                  pend = rsp_q.pop_front();
                  chk(got == e, tag_of(e), "transaction", got, e);
                  if (txn_seen == 1)
                     chk(cyc - last_done_cyc >= GAP, "R2", "reset spacing", cyc - last_done_cyc, GAP);
                  if (txn_seen == 2)
                     chk(cyc - last_done_cyc >= SETTLE, "R2", "settle wait", cyc - last_done_cyc, SETTLE);
                  if (e[45:38] == 8'h0F && prev_busy)
                     chk(cyc - last_done_cyc >= PGAP, "R4", "poll spacing", cyc - last_done_cyc, PGAP);
                  prev_busy = (e[45:38] == 8'h0F) && pend[0];
               end
               txn_seen++;
               wait_cnt = LAT;
            end
         end
      end
   end

   // per-clock comparison of the completion outputs
   initial begin
      forever begin
         @(negedge clk);
         if (!rst_n) prev_done = 0;
         else begin
            chk(!(prev_done && !done), "R11", "done dropped", done, 1);
            chk(err == 2'd0 || done, "R3", "error without done", err, 0);
            prev_done = done;
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_start();
      start = 1'b1; @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 60000 && !done; i++) @(negedge clk);
   endtask

   task automatic read_bit(int b, output logic v);
      rd_blk = BW'(b); @(negedge clk); v = rd_bad;
   endtask

   task automatic mark(int b);
      mark_blk = BW'(b); mark_valid = 1'b1; @(negedge clk); mark_valid = 1'b0;
   endtask

   initial begin
      logic v;
      int tseen, c0;
      do_reset();
      // R1: reset state
      chk(done == 0, "R1", "done", done, 0);
      chk(err == 0, "R1", "err", err, 0);
      chk(bad_count == 0, "R1", "count", bad_count, 0);
      chk(spi_start == 0, "R1", "request", spi_start, 0);
      read_bit(5, v);
      chk(v == 0, "R1", "map bit", v, 0);

      // full scan, open lock
      build(16'h2C12, 0, -1);
      ro_strap = 1'b0;
      pulse_start();
      wait_done();
      chk(done == 1, "R8", "done", done, 1);
      chk(err == 0, "R8", "err", err, 0);
      chk(exp_q.size() == 0, "R8", "missing transactions", exp_q.size(), 0);
      chk(bad_count == CW'(exp_cnt), "R9", "count", bad_count, exp_cnt);
      for (int b = 0; b < NB; b++) begin
         read_bit(b, v);
         chk(v == exp_bits[b], (fact_byte(b) != 8'hFF) ? "R5" : "R6",
             $sformatf("map bit %0d", b), v, exp_bits[b]);
      end

      // R11: start after done is ignored
      tseen = txn_seen;
      pulse_start();
      repeat (30) @(negedge clk);
      chk(txn_seen == tseen, "R11", "restart after done", txn_seen, tseen);
      chk(done == 1, "R11", "done held", done, 1);

      // R10: run-time marking
      c0 = exp_cnt;
      mark(5);
      chk(bad_count == CW'(c0), "R10", "re-mark bad block", bad_count, c0);
      mark(0);
      chk(bad_count == CW'(c0 + 1), "R10", "mark good block", bad_count, c0 + 1);
      read_bit(0, v);
      chk(v == 1, "R10", "marked bit", v, 1);

      // second identifier, read-only lock, start while busy ignored
      do_reset();
      build(16'h2C13, 1, -1);
      ro_strap = 1'b1;
      pulse_start();
      ro_strap = 1'b0;
      repeat (200) @(negedge clk);
      pulse_start();
      wait_done();
      chk(err == 0, "R8", "err read-only run", err, 0);
      chk(exp_q.size() == 0, "R11", "sequence after extra start", exp_q.size(), 0);
      chk(bad_count == CW'(exp_cnt), "R9", "count read-only run", bad_count, exp_cnt);

      // unknown device
      do_reset();
      build(16'h1234, 0, -1);
      pulse_start();
      wait_done();
      repeat (10) @(negedge clk);
      chk(err == 2'd1, "R3", "err", err, 1);
      chk(exp_q.size() == 0, "R3", "transactions", exp_q.size(), 0);
      chk(txn_seen == 3, "R3", "no further traffic", txn_seen, 3);
      chk(bad_count == 0, "R3", "count", bad_count, 0);

      // busy timeout at block 20
      do_reset();
      build(16'h2C12, 0, 20);
      pulse_start();
      wait_done();
      repeat (10) @(negedge clk);
      chk(err == 2'd2, "R7", "err", err, 2);
      chk(exp_q.size() == 0, "R7", "transactions", exp_q.size(), 0);
      chk(bad_count == CW'(exp_cnt), "R7", "count before abort", bad_count, exp_cnt);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule